// File: doc/BRIEF.md
# Block Read Command Sequencer

This block terminates the device end of a byte-wide command link in front of block-organised storage. A host sends one read command byte followed by a logical block address spread over several bytes. The sequencer assembles the address, checks it against the active addressing mode, waits a programmable number of cycles, and then reads one fixed-size block from a synchronous backing memory. It returns the block's bytes one at a time on a valid/ready stream and flags the final byte.

Two addressing modes are supported. The narrow mode honours only the low 28 bits of the block address and rejects anything above that range. The wide mode accepts the full 48-bit block address. Each block address names a whole block of `BLOCK_BYTES` bytes. The backing memory sees a byte address made of the block address with the in-block offset appended below it, so consecutive block addresses map to consecutive blocks.

Top module: `blk_read_seq`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, out_last is 0 and cmd_err is 0. Only the byte value CMD_READ (default 8'h20) starts a read.
- R2: After the command byte, exactly six further accepted bytes form the 48-bit block address, most significant byte first.
- R3: The memory byte address is {block address, 9-bit offset}, and read data arrives one cycle after mem_rd_en. The bytes of a block are returned in increasing offset order from 0 to 511.
- R4: With ext_mode at 0 when the sixth address byte is accepted, any 1 in address bits 47:28 raises cmd_err for exactly the next cycle. No data is returned and the block goes back to waiting for a command.
- R5: With ext_mode at 1, every 48-bit address is served. With ext_mode at 0, addresses up to 0x0FFFFFFF are served.
- R6: The first out_valid comes exactly LATENCY+2 cycles after the clock edge that accepts the sixth address byte. After each accepted byte other than the last, the next out_valid comes 2 cycles later.
- R7: in_ready is 0 from the edge that accepts the sixth address byte until the last data byte is accepted. No command byte is taken in that window.
- R8: Exactly 512 bytes are returned per read, and out_last is 1 only together with the 512th byte.
- R9: A command byte other than CMD_READ is consumed, raises cmd_err for the next cycle, and leaves the block waiting for a command.
- R10: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_mode | input | 1 | 1 selects 48-bit addressing, 0 selects 28-bit |
| in_valid | input | 1 | Command/address byte present |
| in_data | input | 8 | Command or address byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| mem_rd_en | output | 1 | Backing memory read strobe |
| mem_addr | output | 57 | Backing memory byte address |
| mem_rdata | input | 8 | Backing memory data, one cycle after the strobe |
| out_valid | output | 1 | Data byte present |
| out_data | output | 8 | Data byte |
| out_last | output | 1 | Marks the final byte of the block |
| out_ready | input | 1 | Consumer takes the byte |
| cmd_err | output | 1 | One-cycle pulse on an unknown command or an out-of-range address |

## Verification
The embedded properties assume that the backing memory answers every strobe with data on the following cycle. They also assume that the consumer only uses out_ready as a plain acceptance signal, and that the host keeps in_data steady while in_valid waits on in_ready. The bench memory is a registered function of the address, so each returned byte depends on every address bit and on the order of the bytes. The host model holds each byte until it has been accepted. It changes ext_mode only between a command's final address byte and the next one, and it raises in_valid during streaming to probe the input block. out_ready is randomised throughout so that stalls land on every byte position, including the last.

// File: rtl/blk_seq_pkg.sv
package blk_seq_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_ADDR,
      SQ_WAIT,
      SQ_STREAM
   } seq_state_t;

   typedef enum logic [1:0] {
      ST_OFF,
      ST_FETCH,
      ST_LOAD,
      ST_SEND
   } strm_state_t;
endpackage

// File: rtl/blk_lba_capture.sv
module blk_lba_capture #(
   parameter int LBA_BYTES   = 6,
   parameter int LEGACY_BITS = 28,
   localparam int LBA_W      = 8 * LBA_BYTES,
   localparam int CNT_W      = $clog2(LBA_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             take,
   input  logic [7:0]       byte_in,
   output logic [LBA_W-1:0] lba,
   output logic             is_final,
   output logic             legacy_ovf
);
   generate
      if (LBA_BYTES < 2) begin : g_bad_bytes
         $error("LBA_BYTES must be at least 2");
      end
      if (LEGACY_BITS >= LBA_W || LEGACY_BITS < 1) begin : g_bad_legacy
         $error("LEGACY_BITS must lie inside the address width");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [LBA_W-1:0] shreg;
   logic [LBA_W-1:0] next_val;

   // most significant byte arrives first: shift left, append below
   assign next_val   = {shreg[LBA_W-9:0], byte_in};
   assign is_final   = (cnt == CNT_W'(LBA_BYTES - 1));
   assign legacy_ovf = |next_val[LBA_W-1:LEGACY_BITS];
   assign lba        = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         shreg <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (take) begin
         shreg <= next_val;
         cnt   <= cnt + 1'b1;
      end
   end

   // R2: the sequencer never takes a seventh address byte
   p_take_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (cnt < CNT_W'(LBA_BYTES)));
endmodule

// File: rtl/blk_wait_timer.sv
module blk_wait_timer #(
   parameter int LATENCY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   generate
      if (LATENCY < 1) begin : g_bad_latency
         $error("LATENCY must be at least 1");
      end else if (LATENCY == 1) begin : g_single
         assign done = run;
      end else begin : g_counted
         localparam int CW = $clog2(LATENCY);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt <= '0;
            else if (!run) cnt <= '0;
            else           cnt <= cnt + 1'b1;
         end
         assign done = run && (cnt == CW'(LATENCY - 1));
         // R6: the count restarts on every fresh wait
         p_fresh_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run) |-> (cnt == '0));
      end
   endgenerate
endmodule

// File: rtl/blk_byte_streamer.sv
module blk_byte_streamer
   import blk_seq_pkg::*;
#(
   parameter int LBA_W       = 48,
   parameter int BLOCK_BYTES = 512,
   localparam int OFS_W      = $clog2(BLOCK_BYTES),
   localparam int MEM_AW     = LBA_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LBA_W-1:0]  lba,
   output logic              mem_rd_en,
   output logic [MEM_AW-1:0] mem_addr,
   input  logic [7:0]        mem_rdata,
   output logic              out_valid,
   output logic [7:0]        out_data,
   output logic              out_last,
   input  logic              out_ready,
   output logic              done,
   output logic              busy
);
   generate
      if (BLOCK_BYTES < 2 || (BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0) begin : g_bad_block
         $error("BLOCK_BYTES must be a power of two of at least 2");
      end
   endgenerate

   strm_state_t      st;
   logic [OFS_W-1:0] ofs;
   logic [7:0]       data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_OFF;
         ofs    <= '0;
         data_q <= '0;
      end else begin
         case (st)
            ST_OFF: if (start) begin
               st  <= ST_FETCH;
               ofs <= '0;
            end
            ST_FETCH: st <= ST_LOAD;
            ST_LOAD: begin
               data_q <= mem_rdata;
               st     <= ST_SEND;
            end
            ST_SEND: if (out_ready) begin
               if (ofs == OFS_W'(BLOCK_BYTES - 1)) st <= ST_OFF;
               else begin
                  ofs <= ofs + 1'b1;
                  st  <= ST_FETCH;
               end
            end
            default: st <= ST_OFF;
         endcase
      end
   end

   assign mem_rd_en = (st == ST_FETCH);
   assign mem_addr  = {lba, ofs};
   assign out_valid = (st == ST_SEND);
   assign out_data  = data_q;
   assign out_last  = out_valid && (ofs == OFS_W'(BLOCK_BYTES - 1));
   assign done      = out_valid && out_ready && out_last;
   assign busy      = (st != ST_OFF);

   // R10: a stalled byte stays put
   p_hold_stalled_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
   // R3: one strobe per byte, and data is never presented in the strobe's next cycle
   p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> (!mem_rd_en && !out_valid));
   // R8: a new block starts at offset zero
   p_start_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (mem_rd_en && ofs == '0));
endmodule

// File: rtl/blk_read_seq.sv
module blk_read_seq
   import blk_seq_pkg::*;
#(
   parameter logic [7:0] CMD_READ    = 8'h20,
   parameter int         LBA_BYTES   = 6,
   parameter int         LEGACY_BITS = 28,
   parameter int         BLOCK_BYTES = 512,
   parameter int         LATENCY     = 4,
   localparam int        LBA_W       = 8 * LBA_BYTES,
   localparam int        OFS_W       = $clog2(BLOCK_BYTES),
   localparam int        MEM_AW      = LBA_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_mode,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   output logic              in_ready,
   output logic              mem_rd_en,
   output logic [MEM_AW-1:0] mem_addr,
   input  logic [7:0]        mem_rdata,
   output logic              out_valid,
   output logic [7:0]        out_data,
   output logic              out_last,
   input  logic              out_ready,
   output logic              cmd_err
);
   seq_state_t       state;
   logic             err_q;
   logic             acc;
   logic [LBA_W-1:0] lba;
   logic             is_final;
   logic             legacy_ovf;
   logic             timer_done;
   logic             strm_done;
   logic             strm_busy;

   assign in_ready = (state == SQ_IDLE) || (state == SQ_ADDR);
   assign acc      = in_valid && in_ready;
   assign cmd_err  = err_q;

   blk_lba_capture #(.LBA_BYTES(LBA_BYTES), .LEGACY_BITS(LEGACY_BITS)) u_capture (
      .clk(clk), .rst_n(rst_n),
      .clear(state == SQ_IDLE),
      .take(acc && state == SQ_ADDR),
      .byte_in(in_data),
      .lba(lba), .is_final(is_final), .legacy_ovf(legacy_ovf)
   );

   blk_wait_timer #(.LATENCY(LATENCY)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .run(state == SQ_WAIT),
      .done(timer_done)
   );

   blk_byte_streamer #(.LBA_W(LBA_W), .BLOCK_BYTES(BLOCK_BYTES)) u_streamer (
      .clk(clk), .rst_n(rst_n),
      .start(timer_done), .lba(lba),
      .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
      .out_ready(out_ready), .done(strm_done), .busy(strm_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         err_q <= 1'b0;
      end else begin
         err_q <= 1'b0;
         case (state)
            SQ_IDLE: if (acc) begin
               if (in_data == CMD_READ) state <= SQ_ADDR;
               else                     err_q <= 1'b1;
            end
            SQ_ADDR: if (acc && is_final) begin
               if (!ext_mode && legacy_ovf) begin
                  err_q <= 1'b1;
                  state <= SQ_IDLE;
               end else begin
                  state <= SQ_WAIT;
               end
            end
            SQ_WAIT:   if (timer_done) state <= SQ_STREAM;
            SQ_STREAM: if (strm_done)  state <= SQ_IDLE;
            default:   state <= SQ_IDLE;
         endcase
      end
   end

   // R7: input side is closed while the streamer owns the block
   p_closed_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      strm_busy |-> !in_ready);
   // R4: an error pulse never coincides with returned data
   p_err_without_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> (!out_valid && !strm_busy));
   // R6: no memory traffic during the latency wait
   p_quiet_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_WAIT) |-> !mem_rd_en);
   // R9: after an error the sequencer is ready for a new command
   p_err_returns_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> in_ready);
endmodule

// File: tb/blk_read_seq_bench.sv
module blk_read_seq_bench;
   localparam int         LAT  = 3;
   localparam int         BB   = 512;
   localparam logic [7:0] CMD  = 8'h20;
   localparam int         MAW  = 57;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ext_mode = 1'b0;
   logic           in_valid = 1'b0;
   logic [7:0]     in_data = 8'h00;
   logic           in_ready;
   logic           mem_rd_en;
   logic [MAW-1:0] mem_addr;
   logic [7:0]     mem_rdata = 8'h00;
   logic           out_valid;
   logic [7:0]     out_data;
   logic           out_last;
   logic           out_ready = 1'b0;
   logic           cmd_err;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #4 clk = ~clk;

   blk_read_seq #(.CMD_READ(CMD), .LATENCY(LAT)) u_blk_read_seq (
      .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
      .out_ready(out_ready), .cmd_err(cmd_err)
   );

   // order-sensitive fold of the whole byte address
   function automatic logic [7:0] pattern(input logic [MAW-1:0] a);
      logic [63:0] w;
      logic [7:0]  r;
      w = {7'd0, a};
      r = 8'h5A;
      for (int i = 7; i >= 0; i--) r = (r * 8'd31) + w[8*i +: 8];
      return r;
   endfunction

   always @(posedge clk) if (mem_rd_en) mem_rdata <= pattern(mem_addr);

   // reference model: 0 idle, 1 address, 3 returning data
   int          ph = 0;
   int          nbytes = 0;
   int          gap = 0;
   int          ofs = 0;
   logic [47:0] m_lba = '0;
   bit          e_err = 0;

   always @(posedge clk) begin
      bit nerr;
      nerr = 0;
      if (rst_n) begin
         case (ph)
            0: if (in_valid) begin
               if (in_data == CMD) begin ph = 1; nbytes = 0; end
               else nerr = 1;                       // R9
            end
            1: if (in_valid) begin
               m_lba = {m_lba[39:0], in_data};      // R2 MSB first
               nbytes++;
               if (nbytes == 6) begin
                  if (!ext_mode && m_lba[47:28] != 20'd0) begin nerr = 1; ph = 0; end // R4
                  else begin ph = 3; gap = LAT + 2; ofs = 0; end                     // R6
               end
            end
            default: begin
               if (gap > 0) gap--;
               else if (out_ready) begin
                  if (ofs == BB - 1) ph = 0;
                  else begin ofs++; gap = 2; end
               end
            end
         endcase
      end
      e_err = nerr;
   end

   task automatic fail(input string what, input logic [63:0] got, input logic [63:0] exp);
      n_bad++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", what, got, exp, cyc);
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         bit       e_rdy, e_val, e_lst;
         logic [7:0] e_dat;
         logic [8:0] o9;
         o9    = ofs[8:0];
         e_rdy = (ph == 0 || ph == 1);
         e_val = (ph == 3 && gap == 0);
         e_lst = e_val && (ofs == BB - 1);
         e_dat = pattern({m_lba, o9});
         n_cmp++; if (in_ready !== e_rdy) fail("R7 in_ready", 64'(in_ready), 64'(e_rdy));
         n_cmp++; if (cmd_err !== e_err) fail("R4/R9 cmd_err", 64'(cmd_err), 64'(e_err));
         n_cmp++; if (out_valid !== e_val) fail("R6 out_valid", 64'(out_valid), 64'(e_val));
         n_cmp++; if (out_last !== e_lst) fail("R8 out_last", 64'(out_last), 64'(e_lst));
         if (e_val) begin
            n_cmp++; if (out_data !== e_dat) fail("R3 out_data", 64'(out_data), 64'(e_dat));
         end
      end
      out_ready <= ($urandom % 4) != 0;   // R10 stalls at random
   end

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog: got %0d cycles expected completion", cyc);
         summary();
      end
   end

   task automatic put(input logic [7:0] b);
      repeat ($urandom % 3) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = b;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 8'($urandom);
   endtask

   task automatic read_cmd(input logic [47:0] a, input bit mode);
      ext_mode = mode;
      put(CMD);
      for (int i = 5; i >= 0; i--) put(a[8*i +: 8]);
   endtask

   task automatic settle();
      while (ph != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      n_cmp++; if (in_ready !== 1'b1)  fail("R1 in_ready", 64'(in_ready), 64'd1);
      n_cmp++; if (out_valid !== 1'b0) fail("R1 out_valid", 64'(out_valid), 64'd0);
      n_cmp++; if (cmd_err !== 1'b0)   fail("R1 cmd_err", 64'(cmd_err), 64'd0);
      rst_n = 1'b1;
      // R2/R3: small address, byte order matters
      read_cmd(48'h0000_0000_0105, 1'b0); settle();
      // R5: top of legacy range, then an unknown byte offered while streaming (R7, R9)
      read_cmd(48'h0000_0FFF_FFFF, 1'b0); put(8'h77); settle();
      // R4: just past the legacy range, and high bits set
      read_cmd(48'h0000_1000_0000, 1'b0); settle();
      read_cmd(48'hFFFF_0000_0001, 1'b0); settle();
      // R5: wide mode, full range; next command queued behind the stream (R7)
      read_cmd(48'h1234_5678_9ABC, 1'b1);
      read_cmd(48'h8000_0000_0000, 1'b1); settle();
      // R9: more unknown commands
      put(8'h00); put(8'hFF); put(8'h21); settle();
      read_cmd(48'h0000_0000_0501, 1'b0); settle();
      summary();
   end
endmodule